// File: doc/BRIEF.md
# Host Pixel Transfer Window

This block gives a host a 32-bit access window into an 8-bit-per-pixel framebuffer. A command arms it in one of three modes. In load mode, host writes deposit pixels. In dump mode, host reads fetch pixels. In idle mode, window accesses do not reach the framebuffer. Each host access moves four horizontally adjacent pixels. The block turns each access into four byte transfers on a simple synchronous framebuffer port.

When a command is issued, the block captures the rectangle geometry: pitch, row origin, column origin, column limit and row limit. It keeps a current column and row position inside the rectangle. After each completed access it advances the column by four. When the column passes the column limit, it moves to the next row. When the row passes the row limit, it falls back to idle.

Two state machines cooperate. The mode machine has the states IDLE, LOAD and DUMP:
- A command moves it to the mode that the opcode selects.
- The final row advance moves it from LOAD or DUMP back to IDLE.

The access sequencer has the states WAIT, BYTE and ACK:
- WAIT to BYTE: a host request that matches the mode.
- WAIT to ACK: a host request that does not match the mode.
- BYTE to ACK: the fourth byte is accepted.
- ACK to WAIT: always.
- Any state to WAIT: a command.

Top module: `pixel_window`

## Requirements
- R1: After reset, `xfer_mode` is 0 (idle), `fb_req` is low and `host_ack` is low.
- R2: A command with opcode 9 selects load (`xfer_mode`=1). Opcode 10 selects dump (`xfer_mode`=2). Any other opcode selects idle (`xfer_mode`=0). Every command clears the column and row positions to zero. Every command abandons any host access in progress without acknowledging it, and a still-asserted request then restarts under the new mode.
- R3: An active access touches the four byte addresses base, base+1, base+2 and base+3, in that order. The base is pitch*(row origin + row) + column + column origin, taken modulo 2^AW.
- R4: Byte lanes are little-endian. Word bits 7:0 belong to base+0, bits 15:8 to base+1, bits 23:16 to base+2 and bits 31:24 to base+3. This holds for both writes and reads.
- R5: Each completed access adds 4 to the column. If the new column exceeds the column limit, the column returns to 0 and the row increases by 1.
- R6: If the row increase makes the row exceed the row limit, `xfer_mode` returns to idle.
- R7: A host read outside dump mode makes no framebuffer transfer. It is acknowledged with `host_rdata` = 0xDEADBEEF.
- R8: A host write outside load mode makes no framebuffer transfer. It is acknowledged and leaves the position unchanged.
- R9: Geometry inputs are sampled only with a command. Changing them during a transfer has no effect on the addresses used.
- R10: Every byte transfer waits for `fb_ready`, with `fb_req` and `fb_addr` held while waiting. `host_ack` pulses for one cycle, in the cycle after the fourth byte is accepted.
- R11: If a command and a new host request arrive in the same cycle, the command takes effect first. The request is then served under the newly selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode (9 load, 10 dump, other idle) |
| cfg_pitch | input | PW | Framebuffer pitch in bytes |
| cfg_org_y | input | CW | Rectangle row origin |
| cfg_org_x | input | CW | Rectangle column origin |
| cfg_xlim | input | CW | Column limit |
| cfg_ylim | input | CW | Row limit |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 write (load), 0 read (dump) |
| host_wdata | input | 32 | Four packed pixels to write |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 32 | Four packed pixels read, valid with host_ack |
| xfer_mode | output | 2 | Current mode: 0 idle, 1 load, 2 dump |
| fb_req | output | 1 | Framebuffer byte request |
| fb_we | output | 1 | Framebuffer byte write enable |
| fb_addr | output | AW | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write byte |
| fb_ready | input | 1 | Framebuffer accepts the byte this cycle |
| fb_rdata | input | 8 | Framebuffer read byte, valid with fb_ready |

## Verification
Two events can fall in the same cycle: a command, which reloads the mode and clears the position, and a host request, which the sequencer would otherwise start under the old mode. The bench raises both in one cycle. It then checks that the access follows the new mode's address and data.

A second collision happens when a command lands while a read is stalled mid-word because `fb_ready` is held low. The bench judges this by two results. No byte transfer may complete. The held request must come back as an out-of-mode read under the new load mode, returning 0xDEADBEEF.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_DUMP = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_BYTE = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;

    localparam logic [3:0]  OP_LOAD   = 4'h9;
    localparam logic [3:0]  OP_DUMP   = 4'hA;
    localparam logic [31:0] IDLE_WORD = 32'hDEADBEEF;
    localparam int          LANES     = 4;
endpackage

// File: rtl/pixwin_walker.sv
module pixwin_walker
    import pixwin_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 12,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [PW-1:0] cfg_pitch,
    input  logic [CW-1:0] cfg_org_y,
    input  logic [CW-1:0] cfg_org_x,
    input  logic [CW-1:0] cfg_xlim,
    input  logic [CW-1:0] cfg_ylim,
    input  logic          step,
    output mode_e         mode,
    output logic [AW-1:0] base_addr
);
    localparam int XW = CW + 1;

    mode_e         mode_q, mode_d;
    logic [XW-1:0] x_q, x_d, y_q, y_d, x_inc, y_inc;
    logic [PW-1:0] pitch_q;
    logic [CW-1:0] orgy_q, orgx_q, xlim_q, ylim_q;

    // next position and mode
    always_comb begin
        mode_d = mode_q;
        x_d    = x_q;
        y_d    = y_q;
        x_inc  = x_q + XW'(LANES);
        y_inc  = y_q + XW'(1);
        if (cmd_valid) begin
            x_d = '0;
            y_d = '0;
            unique case (cmd_op)
                OP_LOAD: mode_d = MODE_LOAD;
                OP_DUMP: mode_d = MODE_DUMP;
                default: mode_d = MODE_IDLE;
            endcase
        end else if (step && mode_q != MODE_IDLE) begin
            if (x_inc > {1'b0, xlim_q}) begin
                x_d = '0;
                y_d = y_inc;
                if (y_inc > {1'b0, ylim_q}) mode_d = MODE_IDLE;
            end else begin
                x_d = x_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_IDLE;
            x_q     <= '0;
            y_q     <= '0;
            pitch_q <= '0;
            orgy_q  <= '0;
            orgx_q  <= '0;
            xlim_q  <= '0;
            ylim_q  <= '0;
        end else begin
            mode_q <= mode_d;
            x_q    <= x_d;
            y_q    <= y_d;
            if (cmd_valid) begin
                pitch_q <= cfg_pitch;
                orgy_q  <= cfg_org_y;
                orgx_q  <= cfg_org_x;
                xlim_q  <= cfg_xlim;
                ylim_q  <= cfg_ylim;
            end
        end
    end

    // outputs
    always_comb begin
        mode      = mode_q;
        base_addr = AW'(pitch_q) * (AW'(y_q) + AW'(orgy_q)) + AW'(x_q) + AW'(orgx_q);
    end

    a_r5_x_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_IDLE) |-> (x_q <= {1'b0, xlim_q}));
    a_r5_x_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        x_q[1:0] == 2'b00);
    a_r6_row_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_IDLE) |-> (y_q <= {1'b0, ylim_q}));
    a_r2_cmd_clears_pos: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (x_q == '0 && y_q == '0));
endmodule

// File: rtl/pixwin_lane.sv
module pixwin_lane
    import pixwin_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  mode_e         mode,
    input  logic [AW-1:0] base_addr,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [31:0]   host_wdata,
    output logic          host_ack,
    output logic [31:0]   host_rdata,
    output logic          fb_req,
    output logic          fb_we,
    output logic [AW-1:0] fb_addr,
    output logic [7:0]    fb_wdata,
    input  logic          fb_ready,
    input  logic [7:0]    fb_rdata,
    output logic          step
);
    phase_e      ph_q, ph_d;
    logic [1:0]  idx_q;
    logic        we_q;
    logic [31:0] wdata_q, rdata_q;
    logic        hit;

    assign hit = host_we ? (mode == MODE_LOAD) : (mode == MODE_DUMP);

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_WAIT: if (host_req) ph_d = hit ? PH_BYTE : PH_ACK;
            PH_BYTE: if (fb_ready && idx_q == 2'd3) ph_d = PH_ACK;
            PH_ACK:  ph_d = PH_WAIT;
            default: ph_d = PH_WAIT;
        endcase
        if (flush) ph_d = PH_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= PH_WAIT;
            idx_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            ph_q <= ph_d;
            if (!flush) begin
                if (ph_q == PH_WAIT && host_req) begin
                    idx_q   <= '0;
                    we_q    <= host_we;
                    wdata_q <= host_wdata;
                    if (!hit && !host_we) rdata_q <= IDLE_WORD;
                end
                if (ph_q == PH_BYTE && fb_ready) begin
                    idx_q <= idx_q + 2'd1;
                    if (!we_q) rdata_q[{idx_q, 3'b000} +: 8] <= fb_rdata;
                end
            end
        end
    end

    always_comb begin
        fb_req     = (ph_q == PH_BYTE);
        fb_we      = we_q;
        fb_addr    = base_addr + AW'(idx_q);
        fb_wdata   = wdata_q[{idx_q, 3'b000} +: 8];
        host_ack   = (ph_q == PH_ACK);
        host_rdata = rdata_q;
        step       = (ph_q == PH_BYTE) && fb_ready && (idx_q == 2'd3) && !flush;
    end

    a_r10_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_req && !fb_ready && !flush) |=> (fb_req && $stable(fb_addr)));
    a_r10_ack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

// File: rtl/pixel_window.sv
module pixel_window
    import pixwin_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 12,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [PW-1:0] cfg_pitch,
    input  logic [CW-1:0] cfg_org_y,
    input  logic [CW-1:0] cfg_org_x,
    input  logic [CW-1:0] cfg_xlim,
    input  logic [CW-1:0] cfg_ylim,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [31:0]   host_wdata,
    output logic          host_ack,
    output logic [31:0]   host_rdata,
    output logic [1:0]    xfer_mode,
    output logic          fb_req,
    output logic          fb_we,
    output logic [AW-1:0] fb_addr,
    output logic [7:0]    fb_wdata,
    input  logic          fb_ready,
    input  logic [7:0]    fb_rdata
);
    mode_e         mode;
    logic [AW-1:0] base_addr;
    logic          step;

    pixwin_walker #(.CW(CW), .PW(PW), .AW(AW)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cfg_pitch (cfg_pitch),
        .cfg_org_y (cfg_org_y),
        .cfg_org_x (cfg_org_x),
        .cfg_xlim  (cfg_xlim),
        .cfg_ylim  (cfg_ylim),
        .step      (step),
        .mode      (mode),
        .base_addr (base_addr)
    );

    pixwin_lane #(.AW(AW)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cmd_valid),
        .mode       (mode),
        .base_addr  (base_addr),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .fb_req     (fb_req),
        .fb_we      (fb_we),
        .fb_addr    (fb_addr),
        .fb_wdata   (fb_wdata),
        .fb_ready   (fb_ready),
        .fb_rdata   (fb_rdata),
        .step       (step)
    );

    assign xfer_mode = mode;

    a_r8_write_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_req && fb_we) |-> (mode == MODE_LOAD));
    a_r7_read_needs_dump: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_req && !fb_we) |-> (mode == MODE_DUMP));
endmodule

// File: tb/pixel_window_tb.sv
`timescale 1ns/1ps
module pixel_window_tb;
    localparam int CW = 12;
    localparam int PW = 12;
    localparam int AW = 20;
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [PW-1:0] cfg_pitch = '0;
    logic [CW-1:0] cfg_org_y = '0, cfg_org_x = '0, cfg_xlim = '0, cfg_ylim = '0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic          host_ack;
    logic [31:0]   host_rdata;
    logic [1:0]    xfer_mode;
    logic          fb_req, fb_we;
    logic [AW-1:0] fb_addr;
    logic [7:0]    fb_wdata;
    logic          fb_ready = 1'b0;
    logic [7:0]    fb_rdata = '0;

    always #2.5 clk = ~clk;

    pixel_window #(.CW(CW), .PW(PW), .AW(AW)) u_dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit stall = 1'b0;
    logic [7:0] mem [int];
    logic [AW-1:0] log_addr [int];
    int fb_tot = 0;

    // reference state
    int m_mode, m_x, m_y, m_pitch, m_oy, m_ox, m_xl, m_yl;

    function automatic logic [7:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 8'(a * 7 + 3);
    endfunction

    function automatic int m_base();
        return (m_pitch * (m_y + m_oy) + m_x + m_ox) & AMASK;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            summary();
            $finish;
        end
    end

    // framebuffer model
    always @(posedge clk) begin
        if (rst_n && fb_req && fb_ready) begin
            log_addr[fb_tot] = fb_addr;
            if (fb_we) mem[int'(fb_addr)] = fb_wdata;
            fb_tot++;
        end
    end

    always @(negedge clk) begin
        fb_ready = stall ? 1'b0 : ($urandom % 4 != 0);
        fb_rdata = rd(int'(fb_addr));
    end

    function automatic void model_cmd(input int op, input int p, input int oy, input int ox,
                                      input int xl, input int yl);
        m_mode = (op == 9) ? 1 : (op == 10) ? 2 : 0;
        m_x = 0; m_y = 0;
        m_pitch = p; m_oy = oy; m_ox = ox; m_xl = xl; m_yl = yl;
    endfunction

    function automatic void model_step();
        m_x += 4;
        if (m_x > m_xl) begin
            m_x = 0;
            m_y++;
            if (m_y > m_yl) m_mode = 0;
        end
    endfunction

    task automatic drive_cfg(input int op, input int p, input int oy, input int ox,
                             input int xl, input int yl);
        cmd_op = 4'(op); cfg_pitch = PW'(p); cfg_org_y = CW'(oy);
        cfg_org_x = CW'(ox); cfg_xlim = CW'(xl); cfg_ylim = CW'(yl);
    endtask

    task automatic scramble_cfg();
        cfg_pitch = PW'($urandom); cfg_org_y = CW'($urandom); cfg_org_x = CW'($urandom);
        cfg_xlim = CW'($urandom); cfg_ylim = CW'($urandom); cmd_op = 4'($urandom);
    endtask

    task automatic do_cmd(input int op, input int p, input int oy, input int ox,
                          input int xl, input int yl);
        @(negedge clk);
        cmd_valid = 1'b1;
        drive_cfg(op, p, oy, ox, xl, yl);
        @(negedge clk);
        cmd_valid = 1'b0;
        scramble_cfg();   // R9: later geometry changes must be ignored
        model_cmd(op, p, oy, ox, xl, yl);
        chk(xfer_mode == 2'(m_mode), "R2 mode after command", 32'(xfer_mode), 32'(m_mode));
    endtask

    task automatic wait_ack(output logic [31:0] rdata);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 2000);
        chk(host_ack, "R10 ack arrives", 32'(host_ack), 32'd1);
        rdata = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic judge(input bit we, input logic [31:0] data, input logic [31:0] rdata,
                         input bit active, input int base, input int t0);
        int nb = fb_tot - t0;
        if (active) begin
            logic [31:0] expw;
            chk(nb == 4, "R10 four byte transfers", 32'(nb), 32'd4);
            for (int i = 0; i < 4; i++) begin
                int ea = (base + i) & AMASK;
                chk(int'(log_addr[t0 + i]) == ea, "R3 byte address order",
                    32'(log_addr[t0 + i]), 32'(ea));
                expw[8*i +: 8] = rd(ea);
            end
            if (we) chk(expw == data, "R4 written lanes", expw, data);
            else    chk(rdata == expw, "R4 read lanes", rdata, expw);
            model_step();
            chk(xfer_mode == 2'(m_mode), "R5 R6 mode after step", 32'(xfer_mode), 32'(m_mode));
        end else begin
            chk(nb == 0, we ? "R8 no traffic outside load" : "R7 no traffic outside dump",
                32'(nb), 32'd0);
            if (!we) chk(rdata == 32'hDEADBEEF, "R7 idle read word", rdata, 32'hDEADBEEF);
            chk(xfer_mode == 2'(m_mode), "R8 mode unchanged", 32'(xfer_mode), 32'(m_mode));
        end
    endtask

    task automatic do_access(input bit we, input logic [31:0] data);
        bit active = we ? (m_mode == 1) : (m_mode == 2);
        int base = m_base();
        int t0;
        logic [31:0] rdata;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wdata = data;
        t0 = fb_tot;
        wait_ack(rdata);
        judge(we, data, rdata, active, base, t0);
    endtask

    initial begin
        logic [31:0] rdata;
        int t0, base;
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(xfer_mode == 2'd0, "R1 reset mode", 32'(xfer_mode), 32'd0);
        chk(fb_req == 1'b0, "R1 reset fb_req", 32'(fb_req), 32'd0);
        chk(host_ack == 1'b0, "R1 reset host_ack", 32'(host_ack), 32'd0);
        rst_n = 1'b1;
        model_cmd(0, 0, 0, 0, 0, 0);

        // R8: write in idle ignored, R7: read in idle returns fixed word
        do_access(1'b1, 32'h11223344);
        do_access(1'b0, 32'h0);

        // R5 R6: load of 2 rows x 2 words, then one extra write ignored
        do_cmd(9, 32, 2, 5, 7, 1);
        for (int i = 0; i < 4; i++) do_access(1'b1, 32'hA0B0C0D0 + 32'(i * 32'h01010101));
        chk(xfer_mode == 2'd0, "R6 idle after last row", 32'(xfer_mode), 32'd0);
        do_access(1'b1, 32'hFFFFFFFF);

        // R7: read while loading returns fixed word
        do_cmd(9, 16, 0, 0, 3, 0);
        do_access(1'b0, 32'h0);
        // R2: opcode other than 9/10 goes idle
        do_cmd(3, 16, 0, 0, 3, 0);
        chk(xfer_mode == 2'd0, "R2 other opcode idle", 32'(xfer_mode), 32'd0);

        // dump back the rectangle written above (R4 read lanes)
        do_cmd(10, 32, 2, 5, 7, 1);
        while (m_mode != 0) do_access(1'b0, 32'h0);
        do_access(1'b0, 32'h0);

        // R11: command and request in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1;
        drive_cfg(10, 40, 1, 3, 11, 0);
        host_req = 1'b1; host_we = 1'b0;
        t0 = fb_tot;
        @(negedge clk);
        cmd_valid = 1'b0;
        scramble_cfg();
        model_cmd(10, 40, 1, 3, 11, 0);
        base = m_base();
        wait_ack(rdata);
        judge(1'b0, 32'h0, rdata, 1'b1, base, t0);
        chk(m_x == 4, "R11 position advanced under new mode", 32'(m_x), 32'd4);

        // R2: command abandons a stalled access; request re-run as out-of-mode read
        do_cmd(10, 24, 0, 0, 15, 2);
        stall = 1'b1;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0;
        t0 = fb_tot;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1;
        drive_cfg(9, 24, 0, 0, 15, 2);
        @(negedge clk);
        cmd_valid = 1'b0;
        model_cmd(9, 24, 0, 0, 15, 2);
        stall = 1'b0;
        wait_ack(rdata);
        chk(fb_tot == t0, "R2 abandoned access made no transfer", 32'(fb_tot - t0), 32'd0);
        chk(rdata == 32'hDEADBEEF, "R2 restarted under load mode", rdata, 32'hDEADBEEF);
        chk(xfer_mode == 2'd1, "R2 load mode after abort", 32'(xfer_mode), 32'd1);

        // constrained random transfers (R3 R4 R5 R6 R7 R8 R9 R10)
        for (int t = 0; t < 40; t++) begin
            int op = (t % 2 == 0) ? 9 : 10;
            do_cmd(op, 16 + int'($urandom % 49), int'($urandom % 8), int'($urandom % 16),
                   int'($urandom % 16), int'($urandom % 4));
            while (m_mode != 0) begin
                bit stray = ($urandom % 5 == 0);
                bit we = (op == 9) ? !stray : stray;
                do_access(we, $urandom);
            end
            do_access(1'($urandom), $urandom);
        end

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule